// File: doc/BRIEF.md
# Serial Port Byte FIFOs with Level-Driven Flow Control

This block holds the receive and transmit bytes of an 8-bit serial port between the character shifter and a 32-bit register interface. Received characters are pushed into a receive FIFO. Software pops them through a holding-register read. Software writes outgoing characters into a transmit FIFO through a holding-register write, and the shifter drains them one at a time.

The width of each register access decides how many bytes it moves. In packed mode, a 32-bit access moves up to four bytes, and an 8-bit access moves one. The block drops to one byte per access whenever wide (9-bit) characters or one of the single-wire bus protocol modes is selected.

The request-to-send output follows the receive fill level with hysteresis. It goes high once the level reaches the high mark. It goes low once the level drops to the low mark. Between the two marks it keeps its last value.

Top module: `uart_fifo_flow`

## Requirements
- R1: After reset, both levels are 0, `rts` is 0, `rx_overrun` is 0 and `tx_empty` is 1.
- R2: Received bytes come out in arrival order. An 8-bit read returns the oldest byte in bits 7:0, with zero in bits 31:8, and lowers `rx_level` by one.
- R3: In packed mode (`cfg_wide_char`=0 and `cfg_proto`=0), a 32-bit read (`rd_word`=1) pops min(4, level) bytes. The oldest byte is in bits 7:0 and each newer byte is in the next higher lane. Lanes with no byte read as zero.
- R4: In packed mode, a 32-bit write queues the byte lanes in order, starting at bits 7:0. Only as many lanes as there are free entries are queued, lowest lanes first. An 8-bit write queues bits 7:0 only.
- R5: When `cfg_wide_char`=1 or `cfg_proto`≠0, a 32-bit access moves only one byte. A read returns it in bits 7:0 with the upper lanes zero, and a write queues only bits 7:0.
- R6: With `cfg_fc_en`=1, a receive level at or above `cfg_hi_thr` drives `rts` to 1.
- R7: With `cfg_fc_en`=1, a receive level at or below `cfg_lo_thr` (and below `cfg_hi_thr`) drives `rts` to 0. A level strictly between the two marks keeps the previous `rts`.
- R8: With `cfg_fc_en`=0, `rts` is 0 whatever the level.
- R9: A received byte that arrives when the receive FIFO holds 16 entries is dropped. The stored bytes are unchanged, and `rx_overrun` goes to 1 and stays there until reset.
- R10: A read from an empty receive FIFO returns zero and leaves `rx_level` at 0.
- R11: `tx_byte` shows the oldest transmit byte. `tx_pop` removes it and lowers `tx_level`, and `tx_empty` is 1 exactly when `tx_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wide_char | input | 1 | 9-bit character mode, forces one byte per access |
| cfg_proto | input | 2 | 0 normal; nonzero selects a bus protocol mode, forces one byte per access |
| cfg_fc_en | input | 1 | Enables level-driven `rts` |
| cfg_lo_thr | input | 5 | Low mark, at most `cfg_hi_thr` |
| cfg_hi_thr | input | 5 | High mark |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rd_rhr | input | 1 | Receive holding register read strobe |
| rd_word | input | 1 | Read is 32-bit (1) or 8-bit (0) |
| rd_data | output | 32 | Read result, registered |
| wr_thr | input | 1 | Transmit holding register write strobe |
| wr_word | input | 1 | Write is 32-bit (1) or 8-bit (0) |
| wr_data | input | 32 | Write data |
| tx_pop | input | 1 | Shifter takes the head transmit byte |
| tx_byte | output | 8 | Head transmit byte |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_level | output | 5 | Receive entries held |
| tx_level | output | 5 | Transmit entries held |
| rx_overrun | output | 1 | Sticky receive overrun |
| rts | output | 1 | Request-to-send |

## Verification
All outputs that depend on a strobe are due one clock edge after it. `rd_data`, both levels, `rx_overrun` and `rts` are registered on the same edge that sees the strobe, while `tx_byte` and `tx_empty` follow the transmit state without further delay. Expected read words are queued by the driver as it raises the read strobe. A monitor pops one entry for every edge where the strobe was high and compares it a quarter period after that edge. Levels, flags and `rts` are compared on the falling edge that follows the operation's rising edge.

// File: rtl/uart_fifo_flow.sv
module uart_fifo_flow #(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wide_char,
  input  logic [1:0]                 cfg_proto,
  input  logic                       cfg_fc_en,
  input  logic [$clog2(DEPTH):0]     cfg_lo_thr,
  input  logic [$clog2(DEPTH):0]     cfg_hi_thr,
  input  logic                       rx_push,
  input  logic [7:0]                 rx_byte,
  input  logic                       rd_rhr,
  input  logic                       rd_word,
  output logic [DW-1:0]              rd_data,
  input  logic                       wr_thr,
  input  logic                       wr_word,
  input  logic [DW-1:0]              wr_data,
  input  logic                       tx_pop,
  output logic [7:0]                 tx_byte,
  output logic                       tx_empty,
  output logic [$clog2(DEPTH):0]     rx_level,
  output logic [$clog2(DEPTH):0]     tx_level,
  output logic                       rx_overrun,
  output logic                       rts
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int LANES = DW / 8;

  logic [7:0]    rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] rx_rp, rx_wp, tx_rp, tx_wp;
  logic [CW-1:0] rx_cnt, tx_cnt, rx_npop, tx_npush, tx_free, rx_nxt;
  logic [DW-1:0] rd_pack;

  wire single    = cfg_wide_char | (cfg_proto != 2'd0);
  wire rx_acc    = rx_push && (rx_cnt != CW'(DEPTH));
  wire tx_pop_ok = tx_pop && (tx_cnt != '0);
  assign tx_free = CW'(DEPTH) - tx_cnt;

  always_comb begin
    rx_npop = '0;
    if (rd_rhr) begin
      if (rd_word && !single) rx_npop = (rx_cnt > CW'(LANES)) ? CW'(LANES) : rx_cnt;
      else                    rx_npop = (rx_cnt != '0) ? CW'(1) : '0;
    end
    tx_npush = '0;
    if (wr_thr) begin
      if (wr_word && !single) tx_npush = (tx_free > CW'(LANES)) ? CW'(LANES) : tx_free;
      else                    tx_npush = (tx_free != '0) ? CW'(1) : '0;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rd_pack[8*k +: 8] = (CW'(k) < rx_npop) ? rx_mem[rx_rp + AW'(k)] : 8'h00;
  end

  assign rx_nxt = rx_cnt + CW'(rx_acc) - rx_npop;

  always_ff @(posedge clk) begin
    if (rx_acc) rx_mem[rx_wp] <= rx_byte;
    for (int k = 0; k < LANES; k++)
      if (CW'(k) < tx_npush) tx_mem[tx_wp + AW'(k)] <= wr_data[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rd_data <= '0; rx_overrun <= 1'b0; rts <= 1'b0;
    end else begin
      rx_wp  <= rx_wp + AW'(rx_acc);
      rx_rp  <= rx_rp + rx_npop[AW-1:0];
      rx_cnt <= rx_nxt;
      tx_wp  <= tx_wp + tx_npush[AW-1:0];
      tx_rp  <= tx_rp + AW'(tx_pop_ok);
      tx_cnt <= tx_cnt + tx_npush - CW'(tx_pop_ok);
      if (rd_rhr) rd_data <= rd_pack;
      if (rx_push && !rx_acc) rx_overrun <= 1'b1;
      if (!cfg_fc_en)               rts <= 1'b0;
      else if (rx_nxt >= cfg_hi_thr) rts <= 1'b1;
      else if (rx_nxt <= cfg_lo_thr) rts <= 1'b0;
    end
  end

  assign rx_level = rx_cnt;
  assign tx_level = tx_cnt;
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_empty = (tx_cnt == '0);
endmodule

// File: rtl/uart_fifo_flow_chk.sv
module uart_fifo_flow_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_fc_en,
  input logic [$clog2(DEPTH):0] cfg_lo_thr,
  input logic [$clog2(DEPTH):0] cfg_hi_thr,
  input logic                   rx_push,
  input logic                   rd_rhr,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic                   rx_overrun,
  input logic                   rts
);
  p_rts_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> rx_level >= $past(cfg_hi_thr));
  p_rts_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> (!$past(cfg_fc_en) || rx_level <= $past(cfg_lo_thr)));
  p_fc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fc_en |=> !rts);
  p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == ($clog2(DEPTH)+1)'(DEPTH)) |=> rx_overrun);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);
  p_level_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= ($clog2(DEPTH)+1)'(DEPTH));
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rhr && rx_level == '0 && !rx_push) |=> rx_level == '0);
endmodule

bind uart_fifo_flow uart_fifo_flow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fc_en(cfg_fc_en), .cfg_lo_thr(cfg_lo_thr),
  .cfg_hi_thr(cfg_hi_thr), .rx_push(rx_push), .rd_rhr(rd_rhr),
  .rx_level(rx_level), .rx_overrun(rx_overrun), .rts(rts));

// File: tb/uart_fifo_flow_test.sv
module uart_fifo_flow_test;
  logic clk = 0, rst_n = 0;
  logic cfg_wide_char = 0, cfg_fc_en = 0;
  logic [1:0] cfg_proto = 0;
  logic [4:0] cfg_lo_thr = 3, cfg_hi_thr = 8;
  logic rx_push = 0, rd_rhr = 0, rd_word = 0, wr_thr = 0, wr_word = 0, tx_pop = 0;
  logic [7:0] rx_byte = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [7:0] tx_byte;
  logic tx_empty, rx_overrun, rts;
  logic [4:0] rx_level, tx_level;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  byte unsigned rxq[$], txq[$];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  uart_fifo_flow uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic bit single_mode();
    return cfg_wide_char || (cfg_proto != 0);
  endfunction

  task automatic push_rx(byte unsigned b);
    rx_push = 1; rx_byte = b;
    if (rxq.size() < 16) rxq.push_back(b);
    @(negedge clk); rx_push = 0;
  endtask

  task automatic rd(bit word, string tag);
    int n;
    logic [31:0] e = 0;
    n = (word && !single_mode()) ? 4 : 1;
    for (int k = 0; k < n; k++)
      if (rxq.size() > 0) e[8*k +: 8] = rxq.pop_front();
    rd_rhr = 1; rd_word = word;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_rhr = 0;
  endtask

  task automatic wr(bit word, logic [31:0] d);
    int n;
    n = (word && !single_mode()) ? 4 : 1;
    for (int k = 0; k < n; k++)
      if (txq.size() < 16) txq.push_back(d[8*k +: 8]);
    wr_thr = 1; wr_word = word; wr_data = d;
    @(negedge clk); wr_thr = 0;
  endtask

  task automatic pop_tx(string tag);
    chk(tag, {24'd0, tx_byte}, {24'd0, txq.pop_front()});
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  always @(posedge clk) begin
    if (rd_rhr) begin
      #2;
      chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rts", rts, 0);
    chk("R1 overrun", rx_overrun, 0);
    chk("R1 tx_empty", tx_empty, 1);

    cfg_fc_en = 1;
    for (int i = 1; i <= 10; i++) begin
      push_rx(8'h10 + i);
      if (i == 7) chk("R7 rts below high", rts, 0);
      if (i == 8) chk("R6 rts at high", rts, 1);
    end
    chk("R2 level 10", rx_level, 10);
    rd(0, "R2 byte read");
    chk("R2 level 9", rx_level, 9);
    rd(1, "R3 word read");
    chk("R7 rts hold high", rts, 1);
    rd(1, "R3 word read");
    chk("R7 rts low at 1", rts, 0);
    rd(1, "R3 partial word");
    chk("R3 level 0", rx_level, 0);
    rd(0, "R10 empty byte read");
    chk("R10 level stays 0", rx_level, 0);
    rd(1, "R10 empty word read");
    for (int i = 0; i < 5; i++) push_rx(8'h60 + i);
    chk("R7 rts hold low", rts, 0);
    rd(1, "R3 word read"); rd(1, "R3 word read");

    cfg_fc_en = 0;
    for (int i = 0; i < 17; i++) push_rx(8'h40 + i);
    chk("R8 rts off", rts, 0);
    chk("R9 level full", rx_level, 16);
    chk("R9 overrun", rx_overrun, 1);
    for (int i = 0; i < 4; i++) rd(1, "R9 contents");
    chk("R9 overrun sticky", rx_overrun, 1);

    cfg_wide_char = 1;
    for (int i = 0; i < 3; i++) push_rx(8'hA0 + i);
    rd(1, "R5 wide char read");
    chk("R5 level 2", rx_level, 2);
    cfg_wide_char = 0; cfg_proto = 2;
    rd(1, "R5 proto read");
    chk("R5 level 1", rx_level, 1);
    cfg_proto = 0;
    rd(1, "R3 last word");

    wr(1, 32'h44332211);
    chk("R4 tx_level 4", tx_level, 4);
    chk("R4 head", tx_byte, 8'h11);
    wr(0, 32'h999988AA);
    chk("R4 byte write", tx_level, 5);
    wr(1, 32'h04030201); wr(1, 32'h08070605); wr(1, 32'h0C0B0A09);
    chk("R4 partial fit", tx_level, 16);
    chk("R11 not empty", tx_empty, 0);
    for (int i = 0; i < 16; i++) pop_tx("R11 order");
    chk("R11 tx_level 0", tx_level, 0);
    chk("R11 empty", tx_empty, 1);

    cfg_wide_char = 1;
    wr(1, 32'hDDCCBBAA);
    chk("R5 single write level", tx_level, 1);
    pop_tx("R5 single write lane");
    cfg_wide_char = 0;
    chk("R11 empty again", tx_empty, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule